// File: doc/BRIEF.md
# Write-Completion Status Poller

This block sits on the host side of a byte-wide nonvolatile memory. After the host has loaded a page, or issued a whole-array erase, it hands the block the address and value of the last byte it loaded. The block then runs back-to-back read cycles on that one location until the memory's status bits show that the internal write has finished. It reports the result as a one-cycle done pulse, or as a one-cycle error pulse if a cycle-count watchdog expires first.

Two detection schemes are supported. In complement-data mode, bit 7 of a read stays inverted relative to the expected bit 7 while the write runs. In toggle mode, bit 6 flips between consecutive reads while the write runs. The end of the write is not synchronous with the host, so a read can catch it half-way. For that reason any read that looks finished is followed by two confirmation reads. Both must return the exact expected byte before done is reported.

Top module: `wr_poll`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and both mem_ce_no and mem_oe_no are high.
- R2: start_i is taken only while busy_o is low. Taking it latches addr_i, data_i, mode_i and erase_i, and busy_o rises in the next cycle. A start_i pulse while busy_o is high has no effect, and mem_addr_o keeps the latched address.
- R3: While busy, each read holds mem_ce_no and mem_oe_no low for RD_CYC clocks and then high for one clock. The data bus is sampled at the last low clock, and mem_addr_o holds the latched address throughout.
- R4: In complement-data mode (mode_i = 0), a read whose bit 7 equals bit 7 of the expected byte starts confirmation. A read whose bit 7 is inverted keeps polling.
- R5: In toggle mode (mode_i = 1), a read whose bit 6 equals bit 6 of the read just before it starts confirmation. The first read of an operation never does.
- R6: After a read starts confirmation, the next two reads must each equal the expected byte in all 8 bits. done_o then pulses in the cycle after the second one is sampled. A confirmation read that differs returns the block to polling, and that read does not itself start confirmation.
- R7: With erase_i = 1, toggle mode is used and the expected byte is 0xFF, whatever mode_i and data_i are. The watchdog limit is TMO_ER_CYC instead of TMO_WR_CYC.
- R8: busy_o stays high for at most the watchdog limit in cycles. When it expires, err_o pulses. If the final confirmation is sampled in the same cycle that the limit is reached, done_o wins.
- R9: done_o and err_o are single-cycle pulses, never high together, and busy_o is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin polling |
| mode_i | input | 1 | 0 = complement-data, 1 = toggle |
| erase_i | input | 1 | Operation being waited for is a whole-array erase |
| addr_i | input | AW | Address of the last loaded byte |
| data_i | input | 8 | Value of the last loaded byte |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse: write confirmed complete |
| err_o | output | 1 | One-cycle pulse: watchdog expired |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_dq_i | input | 8 | Memory data bus |

## Verification
A wrong confirmation count or a stale bit-6 history does not stay hidden. It shows up at the ports as a done pulse that lands one or more read periods (RD_CYC+1 clocks) away from the predicted cycle, or as a done where an error belongs. A broken read sequencer shows in the very next clock as a chip-enable pattern that departs from the model. A watchdog that loads the wrong limit only shows at the end of the window. The boundary runs therefore place completion exactly on the limit, one read past it, and past the write limit under erase.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int DQ_W    = 8;
  localparam int POLL_B  = 7;  // inverted while write runs
  localparam int TOG_B   = 6;  // flips between reads while write runs
  localparam int CONF_N  = 2;  // confirmation reads

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } poll_mode_e;
endpackage

// File: rtl/poll_rd_seq.sv
module poll_rd_seq #(
  parameter int RD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ce_no,
  output logic oe_no,
  output logic smp_o
);
  localparam int CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

  logic gap_q;
  logic last;

  generate
    if (RD_CYC == 1) begin : g_single
      assign last = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign last = (cnt_q == CW'(RD_CYC - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (!run_i || gap_q)    cnt_q <= '0;
        else if (!last)              cnt_q <= cnt_q + 1'b1;
        else                         cnt_q <= '0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= 1'b0;
    else if (!run_i)   gap_q <= 1'b0;
    else if (gap_q)    gap_q <= 1'b0;
    else if (last)     gap_q <= 1'b1;
  end

  assign ce_no = !(run_i && !gap_q);
  assign oe_no = !(run_i && !gap_q);
  assign smp_o = run_i && !gap_q && last;
endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import poll_pkg::*;
(
  input  poll_mode_e       mode_i,
  input  logic [DQ_W-1:0]  exp_i,
  input  logic [DQ_W-1:0]  dq_i,
  input  logic             prev_tog_i,
  input  logic             have_prev_i,
  output logic             hit_o,
  output logic             match_o
);
  always_comb begin
    match_o = (dq_i == exp_i);
    if (mode_i == MODE_TOGGLE) hit_o = have_prev_i && (dq_i[TOG_B] == prev_tog_i);
    else                       hit_o = (dq_i[POLL_B] == exp_i[POLL_B]);
  end
endmodule

// File: rtl/poll_wdog.sv
module poll_wdog #(
  parameter int TMO_WR_CYC = 1_200_000,
  parameter int TMO_ER_CYC = 2_400_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic expire_o
);
  localparam int LIM_MAX = (TMO_ER_CYC > TMO_WR_CYC) ? TMO_ER_CYC : TMO_WR_CYC;
  localparam int TW      = $clog2(LIM_MAX + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;

  assign lim      = long_i ? TW'(TMO_ER_CYC - 1) : TW'(TMO_WR_CYC - 1);
  assign expire_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wr_poll.sv
module wr_poll
  import poll_pkg::*;
#(
  parameter int AW         = 18,
  parameter int RD_CYC     = 4,
  parameter int TMO_WR_CYC = 1_200_000,
  parameter int TMO_ER_CYC = 2_400_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic            erase_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DQ_W-1:0] data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            mem_ce_no,
  output logic            mem_oe_no,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DQ_W-1:0] mem_dq_i
);
  localparam int CFW = $clog2(CONF_N + 1);

  logic            busy_q, done_q, err_q, long_q;
  poll_mode_e      mode_q;
  logic [DQ_W-1:0] exp_q;
  logic [AW-1:0]   addr_q;
  logic [CFW-1:0]  conf_q;
  logic            prev_q, have_prev_q;
  logic            smp, hit, match, expire, win;

  poll_rd_seq #(.RD_CYC(RD_CYC)) u_seq (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy_q),
    .ce_no (mem_ce_no), .oe_no(mem_oe_no), .smp_o(smp)
  );

  poll_judge u_judge (
    .mode_i(mode_q), .exp_i(exp_q), .dq_i(mem_dq_i),
    .prev_tog_i(prev_q), .have_prev_i(have_prev_q),
    .hit_o(hit), .match_o(match)
  );

  poll_wdog #(.TMO_WR_CYC(TMO_WR_CYC), .TMO_ER_CYC(TMO_ER_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .long_i(long_q),
    .expire_o(expire)
  );

  assign win = smp && match && (conf_q == CFW'(CONF_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      long_q      <= 1'b0;
      mode_q      <= MODE_DATA;
      exp_q       <= '0;
      addr_q      <= '0;
      conf_q      <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q      <= 1'b1;
          long_q      <= erase_i;
          mode_q      <= (erase_i || mode_i) ? MODE_TOGGLE : MODE_DATA;
          exp_q       <= erase_i ? {DQ_W{1'b1}} : data_i;
          addr_q      <= addr_i;
          conf_q      <= '0;
          have_prev_q <= 1'b0;
        end
      end else begin
        if (smp) begin
          prev_q      <= mem_dq_i[TOG_B];
          have_prev_q <= 1'b1;
          if (conf_q == '0) begin
            if (hit) conf_q <= CFW'(1);
          end else if (match) begin
            conf_q <= conf_q + 1'b1;
          end else begin
            conf_q <= '0;
          end
        end
        if (win) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (expire) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign mem_addr_o = addr_q;
endmodule

// File: rtl/wr_poll_chk.sv
module wr_poll_chk #(
  parameter int AW         = 18,
  parameter int TMO_ER_CYC = 2_400_000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          mem_ce_no,
  input logic          mem_oe_no,
  input logic [AW-1:0] mem_addr_o
);
  int run_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  a_r1_idle_bus_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_ce_no && mem_oe_no));
  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r9_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  a_r9_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> $past(busy_o));
  a_r8_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_len < TMO_ER_CYC));
endmodule

bind wr_poll wr_poll_chk #(.AW(AW), .TMO_ER_CYC(TMO_ER_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
  .mem_addr_o(mem_addr_o)
);

// File: tb/tb_wr_poll.sv
`timescale 1ns/1ps
module tb_wr_poll;
  localparam int AW = 18;
  localparam int RD = 3;
  localparam int LW = 79;
  localparam int LE = 159;

  logic clk_i = 0, rst_ni = 0, start_i = 0, mode_i = 0, erase_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0, mem_dq_i;
  logic busy_o, done_o, err_o, mem_ce_no, mem_oe_no;
  logic [AW-1:0] mem_addr_o;

  always #5 clk_i = ~clk_i;

  wr_poll #(.AW(AW), .RD_CYC(RD), .TMO_WR_CYC(LW), .TMO_ER_CYC(LE)) dut (.*);

  int errors = 0, checks = 0;
  string cur_req = "R1";

  // memory read script
  logic [7:0] q[$];
  logic [7:0] fin = 8'h00, cur = 8'h00;
  int ridx = 0;
  always @(negedge mem_ce_no) begin
    cur = (ridx < q.size()) ? q[ridx] : fin;
    ridx++;
  end
  assign mem_dq_i = cur;

  function automatic logic [7:0] byte_at(int i);
    return (i < q.size()) ? q[i] : fin;
  endfunction

  function automatic int concl(bit tog, logic [7:0] ex);
    int conf = 0;
    bit hp = 0;
    logic p6 = 0;
    logic [7:0] b;
    for (int i = 0; i < 64; i++) begin
      b = byte_at(i);
      if (conf == 0) begin
        if (tog ? (hp && b[6] == p6) : (b[7] == ex[7])) conf = 1;
      end else if (b == ex) begin
        if (conf == 2) return i;
        conf++;
      end else conf = 0;
      p6 = b[6];
      hp = 1;
    end
    return -1;
  endfunction

  // reference model
  bit m_act = 0, m_err = 0, p_err = 0;
  int m_n = 0, m_end = 0, p_end = 0;
  logic [AW-1:0] m_addr = '0;
  int n_done = 0, n_err = 0;

  always @(posedge clk_i) begin
    bit b;
    b = m_act && (m_n < m_end);
    if (m_act) m_n++;
    if (rst_ni && start_i && !b) begin
      m_act = 1; m_n = 0; m_end = p_end; m_err = p_err; m_addr = addr_i;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    bit eb, ed, ee, ece;
    eb  = m_act && m_n < m_end;
    ed  = m_act && m_n == m_end && !m_err;
    ee  = m_act && m_n == m_end && m_err;
    ece = !(eb && (m_n % (RD + 1)) < RD);
    if (done_o) n_done++;
    if (err_o)  n_err++;
    chk(busy_o == eb && done_o == ed && err_o == ee &&
        mem_ce_no == ece && mem_oe_no == ece && (!eb || mem_addr_o == m_addr),
        cur_req, "per-clock {busy,done,err,ce,oe}",
        {busy_o, done_o, err_o, mem_ce_no, mem_oe_no},
        {eb, ed, ee, ece, ece});
  end

  task automatic run_op(string req, bit md, bit er, logic [AW-1:0] a, logic [7:0] d,
                        bit poke);
    int k, dat, lim;
    bit tog;
    logic [7:0] ex;
    cur_req = req;
    tog = md | er;
    ex  = er ? 8'hFF : d;
    lim = er ? LE : LW;
    k   = concl(tog, ex);
    dat = (k >= 0) ? k * (RD + 1) + RD : 1 << 30;
    if (dat <= lim) begin p_end = dat; p_err = 0; end
    else            begin p_end = lim; p_err = 1; end
    n_done = 0; n_err = 0; ridx = 0;
    @(negedge clk_i);
    start_i = 1; mode_i = md; erase_i = er; addr_i = a; data_i = d;
    @(negedge clk_i);
    start_i = 0; addr_i = '0; data_i = '0;
    if (poke) begin
      // R2: start while busy must be ignored
      repeat (5) @(negedge clk_i);
      start_i = 1; addr_i = ~a; data_i = ~d; mode_i = ~md;
      @(negedge clk_i);
      start_i = 0;
      chk(mem_addr_o == a, "R2", "address after ignored start", mem_addr_o, a);
    end
    repeat (p_end + 4) @(negedge clk_i);
    chk(n_done == (p_err ? 0 : 1), req, "done pulse cycles", n_done, p_err ? 0 : 1);
    chk(n_err == (p_err ? 1 : 0), req, "err pulse cycles", n_err, p_err ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && mem_ce_no && mem_oe_no, "R1", "reset outputs",
        {busy_o, done_o, err_o, mem_ce_no, mem_oe_no}, 5'b00011);
    rst_ni = 1;
    @(negedge clk_i);

    // R4 R6 R3: complement-data, three busy reads then settled
    q = {8'h00, 8'h00, 8'h00}; fin = 8'hA5;
    run_op("R4", 0, 0, 18'h1_2345, 8'hA5, 1);

    // R6: conflict during confirmation returns to polling
    q = {8'h25, 8'h80, 8'h25, 8'h25}; fin = 8'hA5;
    run_op("R6", 0, 0, 18'h0_0F0F, 8'hA5, 0);

    // R5: toggle mode
    q = {8'h40, 8'h00, 8'h40, 8'h00}; fin = 8'h3C;
    run_op("R5", 1, 0, 18'h2_AAAA, 8'h3C, 0);

    // R7: erase forces toggle, 0xFF expected, long limit (done beyond LW)
    q.delete();
    for (int i = 0; i < 20; i++) q.push_back((i % 2) ? 8'h00 : 8'h40);
    fin = 8'hFF;
    run_op("R7", 0, 1, 18'h0_0001, 8'h12, 0);

    // R8: never completes
    q.delete(); fin = 8'h00;
    run_op("R8", 0, 0, 18'h3_0000, 8'h80, 0);

    // R8: completion exactly at the limit wins
    q.delete();
    for (int i = 0; i < 17; i++) q.push_back(8'h00);
    fin = 8'hA5;
    run_op("R8", 0, 0, 18'h0_1234, 8'hA5, 0);

    // R8: one read too late
    q.push_back(8'h00);
    run_op("R8", 0, 0, 18'h0_1234, 8'hA5, 0);

    // R9: back-to-back operation after error
    q = {8'h00}; fin = 8'h5A;
    run_op("R9", 0, 0, 18'h1_1111, 8'h5A, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule